// File: doc/BRIEF.md
# Table-Seeded Square Root Estimator

This block approximates the square root of a normalised 32-bit significand whose top bit is set. The low bit of the accompanying exponent picks one of two scalings. With that bit set, the block estimates sqrt(sig_in * 2^31). With it clear, it estimates sqrt(sig_in * 2^32). Either way the 32-bit answer lies strictly within 2 of the exact value. A floating-point square root datapath uses it as a seed or as a coarse result. That datapath still owns the exponent, the rounding and any remainder correction.

The estimate starts from a 16-entry correction table for each parity, indexed by bits 30..27 of the significand, which gives a 16-bit seed. One division of the significand by that seed, followed by an averaging step, refines the seed. A second, wide division followed by a halved add forms the result. Both divisions run on one shared restoring divider. The short pass takes 32 steps and the wide pass takes 64. In the even case a very large refined value saturates. When the refined value does not exceed the input, the block skips the second division and returns the input halved with its top bit copied down.

The controller has six named states:
- `ST_IDLE` waits for `start`.
- `ST_LOAD_SEED` launches the short division.
- `ST_DIV_SEED` waits for it to finish.
- `ST_LOAD_FINAL` launches the wide division.
- `ST_DIV_FINAL` waits for it to finish.
- `ST_DONE` raises `done` for one cycle.

The transitions are:
- `ST_IDLE` goes to `ST_LOAD_SEED` on `start`.
- `ST_LOAD_SEED` goes to `ST_DIV_SEED` unconditionally.
- `ST_DIV_SEED` goes to `ST_DONE` when the divider finishes and the even shortcut applies, and to `ST_LOAD_FINAL` when it finishes and the shortcut does not apply.
- `ST_LOAD_FINAL` goes to `ST_DIV_FINAL` unconditionally.
- `ST_DIV_FINAL` goes to `ST_DONE` when the divider finishes.
- `ST_DONE` goes to `ST_IDLE` unconditionally.

Top module: `sqrt_estimator`

## Requirements
- R1: While reset is held and in the first cycle after it, busy and done are 0 and root is 0.
- R2: A start seen at a clock edge while both busy and done are low captures sig_in and exp_lsb at that edge, and busy is high from the next cycle on.
- R3: done is high for exactly one cycle per operation, busy is low in that cycle, and both stay low afterwards until the next start.
- R4: With exp_lsb = 1, root differs from sqrt(sig_in * 2^31) by strictly less than 2, for any sig_in with bit 31 set.
- R5: With exp_lsb = 0, root differs from sqrt(sig_in * 2^32) by strictly less than 2, for any sig_in with bit 31 set.
- R6: An operation that runs both divisions raises done exactly 100 clock edges after the edge that accepted start. Every operation with exp_lsb = 1 is of this kind.
- R7: In the even case, a refined value of 0x20000 or more saturates to 0xFFFF8000. If the refined value is at most sig_in, root becomes {sig_in[31], sig_in[31:1]} and done rises 34 edges after the accepting edge. For example, sig_in = 0xFFFFFFFF with exp_lsb = 0 gives root = 0xFFFFFFFF after 34 edges.
- R8: A start asserted while busy is high is ignored, together with any change on sig_in or exp_lsb. The running operation keeps its result and its timing.
- R9: root changes only at the edge that raises done, and holds its value until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new estimate; taken only while idle |
| sig_in | input | 32 | Normalised significand, bit 31 must be 1 |
| exp_lsb | input | 1 | Low bit of the exponent: 1 odd scaling, 0 even scaling |
| busy | output | 1 | An estimate is in progress |
| done | output | 1 | One-cycle pulse when root holds a new result |
| root | output | 32 | Estimated scaled square root |

## Verification
An internal fault shows up at the ports in one of two ways. A wrong table entry, seed, refinement or divider step pushes root outside the ±2 band against a real-valued square root. A mis-sequenced state moves the done pulse away from edge 100, or away from edge 34 on the even shortcut. Either symptom appears at the very next done, no more than 100 cycles after the start that triggered it. Random significands of both parities sweep every table index. Directed inputs at the ends of the range and at index boundaries reach the saturation path and the shortcut path. Extra starts sent while busy confirm that a running estimate cannot be disturbed.

// File: rtl/sqrt_est_pkg.sv
package sqrt_est_pkg;

    localparam int unsigned SIG_W  = 32;
    localparam int unsigned WIDE_W = 2 * SIG_W;
    localparam int unsigned IDX_W  = 4;
    localparam int unsigned ADJ_W  = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_SEED,
        ST_DIV_SEED,
        ST_LOAD_FINAL,
        ST_DIV_FINAL,
        ST_DONE
    } est_state_e;

    // correction subtracted from the seed when the exponent is odd
    function automatic logic [ADJ_W-1:0] adj_odd(input logic [IDX_W-1:0] idx);
        logic [ADJ_W-1:0] v;
        unique case (idx)
            4'd0:  v = 12'h004;
            4'd1:  v = 12'h022;
            4'd2:  v = 12'h05D;
            4'd3:  v = 12'h0B1;
            4'd4:  v = 12'h11D;
            4'd5:  v = 12'h19F;
            4'd6:  v = 12'h236;
            4'd7:  v = 12'h2E0;
            4'd8:  v = 12'h39C;
            4'd9:  v = 12'h468;
            4'd10: v = 12'h545;
            4'd11: v = 12'h631;
            4'd12: v = 12'h72B;
            4'd13: v = 12'h832;
            4'd14: v = 12'h946;
            default: v = 12'hA67;
        endcase
        return v;
    endfunction

    // correction subtracted from the seed when the exponent is even
    function automatic logic [ADJ_W-1:0] adj_even(input logic [IDX_W-1:0] idx);
        logic [ADJ_W-1:0] v;
        unique case (idx)
            4'd0:  v = 12'hA2D;
            4'd1:  v = 12'h8AF;
            4'd2:  v = 12'h75A;
            4'd3:  v = 12'h629;
            4'd4:  v = 12'h51A;
            4'd5:  v = 12'h429;
            4'd6:  v = 12'h356;
            4'd7:  v = 12'h29E;
            4'd8:  v = 12'h200;
            4'd9:  v = 12'h179;
            4'd10: v = 12'h109;
            4'd11: v = 12'h0AF;
            4'd12: v = 12'h068;
            4'd13: v = 12'h034;
            4'd14: v = 12'h012;
            default: v = 12'h002;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sqrt_seed_gen.sv
module sqrt_seed_gen
    import sqrt_est_pkg::*;
#(
    parameter int unsigned HI_W = 15
) (
    input  logic [HI_W-1:0]  sig_hi,
    input  logic             odd,
    output logic [SIG_W-1:0] seed
);
    localparam logic [SIG_W-1:0] BASE_ODD  = 32'h0000_4000;
    localparam logic [SIG_W-1:0] BASE_EVEN = 32'h0000_8000;

    logic [IDX_W-1:0] idx;
    logic [ADJ_W-1:0] adj;
    logic [SIG_W-1:0] base;

    always_comb begin
        idx  = sig_hi[HI_W-2 -: IDX_W];
        adj  = odd ? adj_odd(idx) : adj_even(idx);
        base = odd ? BASE_ODD : BASE_EVEN;
        seed = base + SIG_W'(sig_hi) - SIG_W'(adj);
    end

endmodule

// File: rtl/sqrt_refine.sv
module sqrt_refine
    import sqrt_est_pkg::*;
(
    input  logic [SIG_W-1:0] sig,
    input  logic             odd,
    input  logic [SIG_W-1:0] seed,
    input  logic [SIG_W-1:0] quot,
    output logic [SIG_W-1:0] z_ref,
    output logic [SIG_W-1:0] sig_scaled,
    output logic             take_short,
    output logic [SIG_W-1:0] short_val
);
    localparam logic [SIG_W-1:0] SAT_LIMIT = 32'h0002_0000;
    localparam logic [SIG_W-1:0] SAT_VALUE = 32'hFFFF_8000;

    logic [SIG_W-1:0] even_sum;

    always_comb begin
        even_sum  = quot + seed;
        short_val = {sig[SIG_W-1], sig[SIG_W-1:1]};
        if (odd) begin
            z_ref      = (quot << 14) + (seed << 15);
            sig_scaled = sig >> 1;
            take_short = 1'b0;
        end else begin
            z_ref      = (even_sum >= SAT_LIMIT) ? SAT_VALUE : (even_sum << 15);
            sig_scaled = sig;
            take_short = (z_ref <= sig);
        end
    end

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
    parameter int unsigned NUM_W = 64,
    parameter int unsigned DEN_W = 32,
    localparam int unsigned CNT_W = $clog2(NUM_W + 1),
    localparam int unsigned HALF  = NUM_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             long_op,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic [DEN_W-1:0] quot,
    output logic             fin
);
    logic [NUM_W-1:0] q_sh;
    logic [DEN_W:0]   rem;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic [DEN_W:0]   trial;
    logic             fits;

    always_comb begin
        trial = {rem[DEN_W-1:0], q_sh[NUM_W-1]};
        fits  = (trial >= {1'b0, divisor});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_sh    <= '0;
            rem     <= '0;
            cnt     <= '0;
            running <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                q_sh    <= long_op ? dividend : {dividend[HALF-1:0], {(NUM_W-HALF){1'b0}}};
                rem     <= '0;
                cnt     <= long_op ? CNT_W'(NUM_W) : CNT_W'(HALF);
                running <= 1'b1;
            end else if (running) begin
                q_sh <= {q_sh[NUM_W-2:0], fits};
                rem  <= fits ? (trial - {1'b0, divisor}) : trial;
                cnt  <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
        end
    end

    assign quot = q_sh[DEN_W-1:0];

    assert_go_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !running);
    assert_fin_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
    assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (rem < {1'b0, divisor}));

endmodule

// File: rtl/sqrt_estimator.sv
module sqrt_estimator
    import sqrt_est_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIG_W-1:0]  sig_in,
    input  logic              exp_lsb,
    output logic              busy,
    output logic              done,
    output logic [SIG_W-1:0]  root
);
    localparam int unsigned SEED_SHIFT = 17;
    localparam int unsigned HI_W       = SIG_W - SEED_SHIFT;
    localparam int unsigned FRAC_SH    = SIG_W - 1;

    est_state_e state_q, state_d;

    logic [SIG_W-1:0]  sig_r, num_r, z_r, root_q;
    logic              odd_r;
    logic [SIG_W-1:0]  seed, z_ref, sig_scaled, short_val;
    logic              take_short;
    logic              div_go, div_long, div_fin;
    logic [WIDE_W-1:0] dividend;
    logic [SIG_W-1:0]  divisor, quot;

    sqrt_seed_gen #(.HI_W(HI_W)) u_seed (
        .sig_hi (sig_r[SIG_W-1:SEED_SHIFT]),
        .odd    (odd_r),
        .seed   (seed)
    );

    sqrt_refine u_refine (
        .sig        (sig_r),
        .odd        (odd_r),
        .seed       (seed),
        .quot       (quot),
        .z_ref      (z_ref),
        .sig_scaled (sig_scaled),
        .take_short (take_short),
        .short_val  (short_val)
    );

    restoring_divider #(.NUM_W(WIDE_W), .DEN_W(SIG_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .long_op  (div_long),
        .dividend (dividend),
        .divisor  (divisor),
        .quot     (quot),
        .fin      (div_fin)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = ST_LOAD_SEED;
            ST_LOAD_SEED:  state_d = ST_DIV_SEED;
            ST_DIV_SEED:   if (div_fin) state_d = take_short ? ST_DONE : ST_LOAD_FINAL;
            ST_LOAD_FINAL: state_d = ST_DIV_FINAL;
            ST_DIV_FINAL:  if (div_fin) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_r  <= '0;
            odd_r  <= 1'b0;
            num_r  <= '0;
            z_r    <= '0;
            root_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sig_r <= sig_in;
                        odd_r <= exp_lsb;
                    end
                end
                ST_DIV_SEED: begin
                    if (div_fin) begin
                        if (take_short) begin
                            root_q <= short_val;
                        end else begin
                            z_r   <= z_ref;
                            num_r <= sig_scaled;
                        end
                    end
                end
                ST_DIV_FINAL: begin
                    if (div_fin) root_q <= quot + (z_r >> 1);
                end
                default: ;
            endcase
        end
    end

    // outputs and divider controls
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        div_go   = 1'b0;
        div_long = 1'b0;
        dividend = {{SIG_W{1'b0}}, sig_r};
        divisor  = z_r;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD_SEED: begin
                busy    = 1'b1;
                div_go  = 1'b1;
                divisor = seed;
            end
            ST_DIV_SEED: begin
                busy    = 1'b1;
                divisor = seed;
            end
            ST_LOAD_FINAL: begin
                busy     = 1'b1;
                div_go   = 1'b1;
                div_long = 1'b1;
                dividend = WIDE_W'(num_r) << FRAC_SH;
            end
            ST_DIV_FINAL: busy = 1'b1;
            ST_DONE:      done = 1'b1;
            default: ;
        endcase
    end

    assign root = root_q;

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> busy);
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_busy_ends_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_root_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(root));
    assert_final_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD_FINAL) |-> (z_r != '0));
    assert_seed_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD_SEED) |-> (seed != '0));

endmodule

// File: tb/sqrt_estimator_bench.sv
`timescale 1ns/1ps
module sqrt_estimator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] sig_in = 32'h8000_0000;
    logic        exp_lsb = 1'b0;
    logic        busy, done;
    logic [31:0] root;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sqrt_estimator u_sqrt_estimator (
        .clk(clk), .rst_n(rst_n), .start(start), .sig_in(sig_in),
        .exp_lsb(exp_lsb), .busy(busy), .done(done), .root(root)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic real exact_root(input logic [31:0] a, input bit odd);
        real scale;
        scale = odd ? 2147483648.0 : 4294967296.0;
        return $sqrt(real'(a) * scale);
    endfunction

    task automatic check_accuracy(input logic [31:0] a, input bit odd, input logic [31:0] r);
        real ex, d;
        ex = exact_root(a, odd);
        d  = real'(r) - ex;
        checks++;
        if (!(d > -2.0 && d < 2.0)) begin
            fails++;
            $display("FAIL %s accuracy sig=0x%08h: actual %0d expected %.3f",
                     odd ? "R4" : "R5", a, r, ex);
        end
    endtask

    // run one estimate; optionally disturb the inputs while busy
    task automatic run_op(input logic [31:0] a, input bit odd, input bit disturb,
                          output logic [31:0] r, output int lat);
        int n;
        @(negedge clk);
        sig_in  = a;
        exp_lsb = odd;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (disturb && n == 10) begin
                sig_in  = ~a | 32'h8000_0000;
                exp_lsb = ~odd;
                start   = 1'b1;
            end else if (disturb && n == 11) begin
                start = 1'b0;
            end
        end while (!done && n < 1000);
        lat = n;
        r   = root;
        check(done, "R6", "done never rose", 0, 1);
        check(!busy, "R3", "busy high during done", longint'(busy), 0);
        @(negedge clk);
        check(!done && !busy, "R3", "done not a single pulse",
              longint'({busy, done}), 0);
    endtask

    task automatic full_op(input logic [31:0] a, input bit odd, input bit disturb);
        logic [31:0] r;
        int lat;
        run_op(a, odd, disturb, r, lat);
        check_accuracy(a, odd, r);
        if (odd) begin
            check(lat == 100, "R6", "odd latency", lat, 100);
        end else if (lat == 34) begin
            check(r == {a[31], a[31:1]}, "R7", "shortcut value", r, {a[31], a[31:1]});
        end else begin
            check(lat == 100, "R6", "even latency", lat, 100);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r, held;
        int lat;
        void'($urandom(32'd4242));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && root == 0, "R1", "during reset", root, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && root == 0, "R1", "after reset",
              longint'({busy, done}), 0);

        // R2: busy after accepted start
        @(negedge clk);
        sig_in = 32'hC000_0000; exp_lsb = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R2", "busy after start", longint'(busy), 1);
        while (!done) @(negedge clk);
        check_accuracy(32'hC000_0000, 1'b1, root);
        @(negedge clk);

        // R7: saturation and shortcut at the top of the range
        run_op(32'hFFFF_FFFF, 1'b0, 1'b0, r, lat);
        check(r == 32'hFFFF_FFFF, "R7", "even all-ones value", r, 32'hFFFF_FFFF);
        check(lat == 34, "R7", "even all-ones latency", lat, 34);

        // directed corners for R4 and R5
        full_op(32'h8000_0000, 1'b1, 1'b0);
        full_op(32'h8000_0000, 1'b0, 1'b0);
        full_op(32'hFFFF_FFFF, 1'b1, 1'b0);
        full_op(32'hFFFF_0000, 1'b0, 1'b0);
        full_op(32'h87FF_FFFF, 1'b1, 1'b0);
        full_op(32'h8800_0000, 1'b0, 1'b0);
        full_op(32'hF800_0000, 1'b1, 1'b0);
        full_op(32'hF7FF_FFFF, 1'b0, 1'b0);

        // R8: start while busy is ignored
        full_op(32'h9ABC_DEF1, 1'b1, 1'b1);
        full_op(32'hA123_4567, 1'b0, 1'b1);

        // R9: root holds while idle and inputs move
        run_op(32'hB000_0001, 1'b1, 1'b0, held, lat);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sig_in  = $urandom;
            exp_lsb = 1'(i);
        end
        check(root == held, "R9", "root while idle", root, held);

        // random sweep of both parities
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            a = $urandom | 32'h8000_0000;
            full_op(a, 1'($urandom), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule